// File: doc/BRIEF.md
# Scanline Endpoint Stream Merger

This block joins two endpoint streams into the single ordered stream that a rule-checking stage consumes for each scanline. One input carries fresh endpoints read from layout memory. The other carries points inherited from the previous scanline: continuing edges and virtual points. Both inputs arrive already sorted, so one comparison per cycle is enough to keep the output sorted. Each input and the output use a valid/ready handshake, and the output is held in a single register.

Points carry no X value. A record on layer 0 opens each group of same-X points and holds that X in its Y field. Both inputs carry such group markers. When the two heads are markers for the same X, they leave as one record. While merging, the block cancels each inherited point against the ending endpoint it matches. It also reduces the remaining extension of every inherited virtual point by the distance the scanline has moved, and discards a virtual point whose extension runs out. When one input has ended, the other drains through alone. A done flag rises once both inputs have ended and the output register is empty.

Top module: `scan_merge`

## Requirements
- R1: A word is laid out as Y in bits 31:14, layer in 13:9, orientation in bit 8, direction in bit 7 (1 = ending endpoint, 0 = starting endpoint or virtual), the processed flag in bit 6 (1 = inherited), and the extension in 5:0. Records are emitted in ascending order of (group X, bits 31:6). A marker sorts ahead of every point of its own X. The extension field takes no part in the order.
- R2: A layer-0 record with bits 31:14 = X is a group marker. When both heads are markers with the same X, one copy is emitted and both inputs advance.
- R3: A new-stream word with bit 7 = 1 and bit 6 = 0 cancels against an old-stream word in the same group that equals it in bits 31:7 and has bit 6 = 1. Neither word is emitted.
- R4: An inherited virtual point (bit 6 = 1, bit 7 = 0) is emitted with its extension reduced by d'. Here d' is the X of the last emitted marker minus the X of the marker emitted before it.
- R5: An inherited virtual point whose extension is less than or equal to d' is discarded.
- R6: After one input delivers its last word, the other input's records pass through in their own order. No cancellation occurs while one input drains alone.
- R7: `done` is high only when both inputs have delivered their last word and `out_valid` is low. Once high, it stays high until reset.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value.
- R9: After reset, `out_valid`, `done`, `new_ready` and `old_ready` are low.
- R10: Until a second marker has been emitted, d' is zero. Virtual points in the first group therefore keep their extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| new_valid | input | 1 | New-endpoint word present |
| new_data | input | 32 | New-endpoint word |
| new_last | input | 1 | Final word of the new stream |
| new_ready | output | 1 | New word accepted this cycle |
| old_valid | input | 1 | Inherited word present |
| old_data | input | 32 | Inherited word |
| old_last | input | 1 | Final word of the inherited stream |
| old_ready | output | 1 | Inherited word accepted this cycle |
| out_valid | output | 1 | Merged word present |
| out_data | output | 32 | Merged word |
| out_ready | input | 1 | Consumer accepts merged word |
| done | output | 1 | Both inputs ended and output empty |

## Verification
The bench sweeps the virtual extension across values on both sides of a fixed step of four. A design that compares with the wrong inequality would let a point with zero extension through, or drop one with extension left. A separate run checks that a virtual point in the very first group is not aged against an undefined previous X. Directed streams place a matching ending endpoint and inherited point side by side in the same group, and put points with equal Y but different layer or orientation next to each other. A design that only compared Y would misorder them, and one that missed the P-only difference would emit duplicates. Every scenario also runs with input gaps and output stalls, and with each input ending first. This exposes a register that changes under stall, a merge that stops early, or a done flag raised while a word is still held.

// File: rtl/scan_merge.sv
module scan_merge #(
  parameter int YW = 18,
  parameter int LW = 5,
  parameter int XW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_valid,
  input  logic [YW+LW+XW+2:0] new_data,
  input  logic              new_last,
  output logic              new_ready,
  input  logic              old_valid,
  input  logic [YW+LW+XW+2:0] old_data,
  input  logic              old_last,
  output logic              old_ready,
  output logic              out_valid,
  output logic [YW+LW+XW+2:0] out_data,
  input  logic              out_ready,
  output logic              done
);
  localparam int W  = YW + LW + 3 + XW;
  localparam int PB = XW;
  localparam int DB = XW + 1;
  localparam int LB = XW + 3;
  localparam int YB = XW + 3 + LW;
  localparam int KW = W - XW;
  localparam int EW = YW + 1 + KW;

  logic          n_end, o_end, have_x, out_v;
  logic [YW-1:0] gx_n, gx_o, cur_x, prev_x;
  logic [W-1:0]  out_d;

  logic n_mk, o_mk, go, both, mrg, cncl, take_n, pop_n, pop_o;
  logic virt, dead, emit, sel_mk;
  logic [EW-1:0] ek_n, ek_o;
  logic [YW-1:0] dstep;
  logic [XW-1:0] aged;
  logic [W-1:0]  sel, word;

  assign n_mk = new_data[YB-1:LB] == '0;
  assign o_mk = old_data[YB-1:LB] == '0;
  assign ek_n = n_mk ? {new_data[W-1:YB], 1'b0, {KW{1'b0}}} : {gx_n, 1'b1, new_data[W-1:XW]};
  assign ek_o = o_mk ? {old_data[W-1:YB], 1'b0, {KW{1'b0}}} : {gx_o, 1'b1, old_data[W-1:XW]};

  assign go   = (n_end | new_valid) & (o_end | old_valid) & ~(n_end & o_end) & (~out_v | out_ready);
  assign both = ~n_end & ~o_end;
  assign mrg  = both & n_mk & o_mk & (ek_n == ek_o);
  assign cncl = both & ~n_mk & ~o_mk & (gx_n == gx_o)
              & (new_data[W-1:DB] == old_data[W-1:DB])
              & new_data[DB] & ~new_data[PB] & old_data[PB];

  assign take_n = o_end | (~n_end & (ek_n <= ek_o));
  assign pop_n  = go & (take_n | mrg | cncl);
  assign pop_o  = go & (~take_n | mrg | cncl);
  assign new_ready = pop_n;
  assign old_ready = pop_o;

  assign sel    = take_n ? new_data : old_data;
  assign sel_mk = take_n ? n_mk : o_mk;
  assign dstep  = cur_x - prev_x;
  assign virt   = ~take_n & ~o_mk & old_data[PB] & ~old_data[DB];
  assign dead   = dstep >= {{(YW-XW){1'b0}}, old_data[XW-1:0]};
  assign aged   = old_data[XW-1:0] - dstep[XW-1:0];
  assign word   = virt ? {old_data[W-1:XW], aged} : sel;
  assign emit   = go & ~cncl & ~(virt & dead);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_end  <= 1'b0;
      o_end  <= 1'b0;
      have_x <= 1'b0;
      gx_n   <= '0;
      gx_o   <= '0;
      cur_x  <= '0;
      prev_x <= '0;
      out_v  <= 1'b0;
      out_d  <= '0;
    end else begin
      if (pop_n && new_last) n_end <= 1'b1;
      if (pop_o && old_last) o_end <= 1'b1;
      if (pop_n && n_mk) gx_n <= new_data[W-1:YB];
      if (pop_o && o_mk) gx_o <= old_data[W-1:YB];
      if (emit && sel_mk) begin
        have_x <= 1'b1;
        cur_x  <= sel[W-1:YB];
        prev_x <= have_x ? cur_x : sel[W-1:YB];
      end
      if (!out_v || out_ready) begin
        out_v <= emit;
        if (emit) out_d <= word;
      end
    end
  end

  assign out_valid = out_v;
  assign out_data  = out_d;
  assign done      = n_end & o_end & ~out_v;
endmodule

// File: rtl/scan_merge_chk.sv
module scan_merge_chk #(
  parameter int YW = 18,
  parameter int LW = 5,
  parameter int XW = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                out_valid,
  input logic                out_ready,
  input logic [YW+LW+XW+2:0] out_data,
  input logic                done
);
  localparam int W  = YW + LW + 3 + XW;
  localparam int LB = XW + 3;
  localparam int YB = XW + 3 + LW;

  logic         prev_pt;
  logic [W-1:0] prev_d;
  logic         cur_mk;
  assign cur_mk = out_data[YB-1:LB] == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_pt <= 1'b0;
      prev_d  <= '0;
    end else if (out_valid && out_ready) begin
      prev_pt <= ~cur_mk;
      prev_d  <= out_data;
    end
  end

  p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && prev_pt && !cur_mk |-> out_data[W-1:XW] >= prev_d[W-1:XW]);
  p_virt_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cur_mk && out_data[XW] && !out_data[XW+1] |-> out_data[XW-1:0] != '0);
  p_done_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind scan_merge scan_merge_chk #(.YW(YW), .LW(LW), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .done(done));

// File: tb/tb_scan_merge.sv
module tb_scan_merge;
  logic clk = 0, rst_n = 0;
  logic new_valid = 0, new_last = 0, old_valid = 0, old_last = 0, out_ready = 0;
  logic [31:0] new_data = 0, old_data = 0;
  logic new_ready, old_ready, out_valid, done;
  logic [31:0] out_data;

  always #2 clk = ~clk;

  scan_merge dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [31:0] nq[$], oq[$], eq[$], got[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pt(int y, int l, bit o, bit d, bit p, int xe);
    return {y[17:0], l[4:0], o, d, p, xe[5:0]};
  endfunction
  function automatic logic [31:0] mk(int x);
    return {x[17:0], 14'd0};
  endfunction

  task automatic drive_new(input int gap);
    for (int i = 0; i < nq.size(); i++) begin
      if (gap != 0 && i % 2 == 1) begin @(posedge clk); #1; end
      new_valid = 1; new_data = nq[i]; new_last = (i == nq.size() - 1);
      do @(negedge clk); while (!new_ready);
      @(posedge clk); #1;
      new_valid = 0; new_last = 0;
    end
  endtask

  task automatic drive_old(input int gap);
    for (int i = 0; i < oq.size(); i++) begin
      if (gap != 0 && i % 2 == 0) begin @(posedge clk); #1; end
      old_valid = 1; old_data = oq[i]; old_last = (i == oq.size() - 1);
      do @(negedge clk); while (!old_ready);
      @(posedge clk); #1;
      old_valid = 0; old_last = 0;
    end
  endtask

  task automatic collect(input int stall, input string tag);
    bit held = 0;
    logic [31:0] hd = 0;
    int cyc = 0;
    out_ready = 1;
    forever begin
      @(negedge clk);
      cyc++;
      if (held) chk(out_valid && out_data == hd, "R8 hold", out_data, hd);
      held = out_valid && !out_ready;
      hd = out_data;
      if (out_valid && out_ready) got.push_back(out_data);
      if (done) break;
      if (cyc > 2000) begin
        chk(0, {tag, " watchdog"}, 0, 0);
        break;
      end
      @(posedge clk); #1;
      out_ready = (stall != 0) ? (cyc % 3 != 0) : 1'b1;
    end
  endtask

  task automatic run(input int gap, input int stall, input string tag);
    got.delete();
    rst_n = 0; new_valid = 0; old_valid = 0; out_ready = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    fork
      drive_new(gap);
      drive_old(gap);
      collect(stall, tag);
    join
    chk(got.size() == eq.size(), {tag, " count"}, got.size(), eq.size());
    for (int i = 0; i < eq.size() && i < got.size(); i++)
      chk(got[i] == eq[i], tag, got[i], eq[i]);
    chk(done == 1'b1 && out_valid == 1'b0, "R7 done", done, 1);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0 && done == 0 && new_ready == 0 && old_ready == 0, "R9 reset",
        {out_valid, done, new_ready, old_ready}, 0);

    // R1 order, R2 marker merge, R3 cancellation, under gaps and stalls
    for (int g = 0; g < 2; g++)
      for (int s = 0; s < 2; s++) begin
        nq = '{mk(10), pt(5,1,0,0,0,0), pt(5,2,0,0,0,0), pt(7,2,0,1,0,0)};
        oq = '{mk(10), pt(3,1,0,1,1,0), pt(5,1,1,1,1,0), pt(7,2,0,1,1,0)};
        eq = '{mk(10), pt(3,1,0,1,1,0), pt(5,1,0,0,0,0), pt(5,1,1,1,1,0), pt(5,2,0,0,0,0)};
        run(g, s, "R1 R2 R3 merge");
      end

    // R4 aging, R5 drop, R6 old drains after new ends
    nq = '{mk(10), pt(2,1,0,0,0,0), mk(13), pt(20,1,0,0,0,0)};
    oq = '{mk(13), pt(4,1,0,0,1,5), pt(6,1,0,0,1,3), pt(8,1,0,0,1,2), pt(30,1,0,1,1,0)};
    eq = '{mk(10), pt(2,1,0,0,0,0), mk(13), pt(4,1,0,0,1,2), pt(20,1,0,0,0,0), pt(30,1,0,1,1,0)};
    run(1, 1, "R4 R5 R6 age");

    // R6 new drains after old ends, unmatched ending endpoint passes
    nq = '{mk(1), pt(1,1,0,0,0,0), pt(2,1,0,0,0,0), pt(9,4,0,1,0,0)};
    oq = '{mk(1)};
    eq = '{mk(1), pt(1,1,0,0,0,0), pt(2,1,0,0,0,0), pt(9,4,0,1,0,0)};
    run(0, 1, "R6 drain");

    // R10 first group: no aging
    nq = '{mk(5)};
    oq = '{mk(5), pt(2,1,0,0,1,4)};
    eq = '{mk(5), pt(2,1,0,0,1,4)};
    run(0, 0, "R10 first");

    // R4 R5 sweep of extension against a step of 4
    for (int xe = 0; xe < 10; xe++) begin
      nq = '{mk(20), mk(24)};
      oq = '{mk(24), pt(1,3,0,0,1,xe)};
      eq = '{mk(20), mk(24)};
      if (xe > 4) eq.push_back(pt(1,3,0,0,1,xe-4));
      run(xe % 2, 0, "R4 R5 sweep");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule